// File: doc/BRIEF.md
# Six-Channel Edge-Programmable PWM Generator

This block produces six logic-level drive signals for an isolated switching converter: four for the primary-side switches and two for the synchronous rectifiers. All six share one timebase whose period is programmable. Each channel has its own turn-on and turn-off positions inside that period, so the same block can serve bridge, half-bridge and forward-style timing without fixed presets. The control loop adds a signed duty offset to every turn-off edge. Period and edge settings are held in shadow registers and take effect only when a new period starts, so a loop update cannot produce a runt pulse.

Time is counted in fine ticks. An edge or period value is `{integer[11:0], fraction[2:0]}`, where the three low bits select one of eight sub-clock phases. In this model the timebase advances one fine tick per clock. The block can run as timing master, where it emits a one-tick pulse at each period start. It can also run as a slave, where a rising edge on the external sync input restarts the period at once. Channels 2 and 3 can each be turned into a sync-pulse output instead of a PWM output. A shutdown input pulls every channel low on the next clock edge.

Top module: `pwm6_edge_gen`

## Requirements
- R1: While `rst` is high, on the following clock edge `pwm_o` becomes all zero and `sync_o` becomes zero. After reset the period shadow is zero, which is treated as the minimum period.
- R2: The timebase counts 0..P-1 and then restarts, where P is the shadowed period. A shadowed period below 2 acts as 2. In master mode (`slave_i`=0), `sync_o` is high for exactly one cycle per period, one cycle after the count is 0.
- R3: A channel's output is high in the cycle after the count value c when rise <= c < fall_eff. Values are in fine ticks: bits [2:0] are the sub-clock fraction and bits [14:3] are whole clocks.
- R4: Period, rise and fall inputs, together with the duty offset, are sampled only when a new period starts. Changes made mid-period do not affect the current period.
- R5: fall_eff = fall + `ofs_i`, where `ofs_i` is two's complement. A negative result is clamped to 0. A result above the period is clamped to the period, so the output is held high until the period ends.
- R6: A channel whose rise is at or above fall_eff stays low for the whole period.
- R7: A channel whose bit in `en_i` is 0 is low on the next clock edge, whatever its edges are.
- R8: When `kill_i` is high, all six outputs are low on the next clock edge.
- R9: When `syncsel_i[0]` is set, channel 2 outputs the one-cycle period-start pulse instead of PWM; `syncsel_i[1]` does the same for channel 3. These pins still obey `en_i` and `kill_i`.
- R10: In slave mode, a rising edge on `sync_i` (high now, low in the previous cycle) forces the count to 0 in the next cycle and loads the shadows. `sync_o` stays low in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine-tick clock |
| rst | input | 1 | Synchronous active-high reset |
| kill_i | input | 1 | Global shutdown, forces all outputs low |
| slave_i | input | 1 | 1 = period restarts on sync_i edge, 0 = free-running master |
| sync_i | input | 1 | External synchronization input |
| period_i | input | 15 | Period in fine ticks |
| rise_i | input | 90 | Six rise positions, channel c at bits [15c+14:15c] |
| fall_i | input | 90 | Six fall positions, same packing as rise_i |
| ofs_i | input | 10 | Signed duty offset added to every fall position |
| en_i | input | 6 | Per-channel enable |
| syncsel_i | input | 2 | Repurpose channel 2 (bit 0) / channel 3 (bit 1) as sync output |
| pwm_o | output | 6 | Registered drive outputs; 0..3 primary, 4..5 rectifier |
| sync_o | output | 1 | Registered period-start pulse in master mode |

## Verification
The bench first targets the clamp paths. An offset large enough to push the fall past the period must hold a channel high to the end of the period. A design that does not clamp, or that clamps against the old period, would leave the channel low or cut it short. A negative result must be clamped to 0 and give a dead channel; without the clamp, the value wraps around to a large number. The bench also changes edges in the middle of a period: a design without shadows would glitch the current pulse. Periods of 0 and 1 are applied to catch a timebase that stalls or wraps through its full range. Slave sync edges arriving mid-period, and the sync pins switching between PWM and sync pulse, are checked cycle by cycle against a reference model.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int unsigned INT_BITS  = 12;
  localparam int unsigned FINE_BITS = 3;
  localparam int unsigned TICK_W    = INT_BITS + FINE_BITS;

  typedef enum logic [1:0] {
    PIN_LOW  = 2'd0,
    PIN_PWM  = 2'd1,
    PIN_SYNC = 2'd2
  } pin_role_t;
endpackage

// File: rtl/pwm6_timebase.sv
module pwm6_timebase #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slave_i,
  input  logic         sync_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] ctr_o,
  output logic [W-1:0] per_eff_o,
  output logic         load_o
);
  localparam logic [W-1:0] MIN_PER = W'(2);

  logic [W-1:0] ctr_q;
  logic [W-1:0] per_q;
  logic         sync_d;
  logic         ext_edge;

  assign per_eff_o = (per_q < MIN_PER) ? MIN_PER : per_q;
  assign ext_edge  = slave_i & sync_i & ~sync_d;
  assign load_o    = (ctr_q >= per_eff_o - W'(1)) | ext_edge;
  assign ctr_o     = ctr_q;

  always_ff @(posedge clk) begin
    sync_d <= sync_i;
    if (rst) begin
      ctr_q <= '0;
      per_q <= '0;
    end else if (load_o) begin
      ctr_q <= '0;
      per_q <= period_i;
    end else begin
      ctr_q <= ctr_q + W'(1);
    end
  end
endmodule

// File: rtl/pwm6_chan.sv
module pwm6_chan
  import pwm6_pkg::*;
#(
  parameter int unsigned W     = 15,
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [W-1:0]     ctr_i,
  input  logic [W-1:0]     period_i,
  input  logic [W-1:0]     rise_i,
  input  logic [W-1:0]     fall_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             en_i,
  input  logic             kill_i,
  input  logic             syncsel_i,
  output logic             pwm_o
);
  localparam int unsigned SW = W + 2;

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] per_s;
  logic [W-1:0]         fall_c;
  logic [W-1:0]         rise_q;
  logic [W-1:0]         fall_q;
  pin_role_t            role;
  logic                 nxt;

  assign sum   = $signed({2'b00, fall_i}) + $signed({{(SW-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
  assign per_s = $signed({2'b00, period_i});

  always_comb begin
    if (sum[SW-1])
      fall_c = '0;
    else if (sum > per_s)
      fall_c = period_i;
    else
      fall_c = sum[W-1:0];
  end

  always_comb begin
    if (kill_i || !en_i)
      role = PIN_LOW;
    else if (syncsel_i)
      role = PIN_SYNC;
    else
      role = PIN_PWM;
  end

  always_comb begin
    unique case (role)
      PIN_PWM:  nxt = (ctr_i >= rise_q) && (ctr_i < fall_q);
      PIN_SYNC: nxt = (ctr_i == '0);
      default:  nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      pwm_o <= nxt;
      if (load_i) begin
        rise_q <= rise_i;
        fall_q <= fall_c;
      end
    end
  end
endmodule

// File: rtl/pwm6_edge_gen.sv
module pwm6_edge_gen #(
  parameter int unsigned NCH   = 6,
  parameter int unsigned W     = pwm6_pkg::TICK_W,
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill_i,
  input  logic             slave_i,
  input  logic             sync_i,
  input  logic [W-1:0]     period_i,
  input  logic [NCH*W-1:0] rise_i,
  input  logic [NCH*W-1:0] fall_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [NCH-1:0]   en_i,
  input  logic [1:0]       syncsel_i,
  output logic [NCH-1:0]   pwm_o,
  output logic             sync_o
);
  localparam int unsigned SYNC_CH0 = 2;

  logic [W-1:0] ctr;
  logic [W-1:0] per_eff;
  logic         load;

  pwm6_timebase #(.W(W)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .slave_i   (slave_i),
    .sync_i    (sync_i),
    .period_i  (period_i),
    .ctr_o     (ctr),
    .per_eff_o (per_eff),
    .load_o    (load)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_o <= 1'b0;
    else     sync_o <= ~slave_i && (ctr == '0);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    if (c == SYNC_CH0 || c == SYNC_CH0 + 1) begin : g_sync_capable
      assign sel = syncsel_i[c - SYNC_CH0];
    end else begin : g_pwm_only
      assign sel = 1'b0;
    end

    pwm6_chan #(.W(W), .OFS_W(OFS_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .load_i    (load),
      .ctr_i     (ctr),
      .period_i  (period_i),
      .rise_i    (rise_i[c*W +: W]),
      .fall_i    (fall_i[c*W +: W]),
      .ofs_i     (ofs_i),
      .en_i      (en_i[c]),
      .kill_i    (kill_i),
      .syncsel_i (sel),
      .pwm_o     (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm6_chk.sv
module pwm6_chk #(
  parameter int unsigned NCH = 6,
  parameter int unsigned W   = 15
) (
  input logic           clk,
  input logic           rst,
  input logic           kill_i,
  input logic           slave_i,
  input logic           sync_i,
  input logic [NCH-1:0] en_i,
  input logic [NCH-1:0] pwm_o,
  input logic           sync_o,
  input logic [W-1:0]   ctr,
  input logic [W-1:0]   per_eff
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pwm_o == '0) && !sync_o);

  a_r2_ctr_in_range: assert property (@(posedge clk) disable iff (rst)
    ctr < per_eff);

  a_r2_sync_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);

  a_r7_disabled_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pwm_o & ~$past(en_i)) == '0));

  a_r8_kill_low: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> (pwm_o == '0));

  a_r10_slave_no_sync_out: assert property (@(posedge clk) disable iff (rst)
    slave_i |=> !sync_o);

  a_r10_slave_restart: assert property (@(posedge clk) disable iff (rst)
    (slave_i && sync_i && !$past(sync_i)) |=> (ctr == '0));
endmodule

bind pwm6_edge_gen pwm6_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .kill_i  (kill_i),
  .slave_i (slave_i),
  .sync_i  (sync_i),
  .en_i    (en_i),
  .pwm_o   (pwm_o),
  .sync_o  (sync_o),
  .ctr     (ctr),
  .per_eff (per_eff)
);

// File: tb/sim_pwm6_edge_gen.sv
module sim_pwm6_edge_gen;
  localparam int NCH = 6;
  localparam int W = 15;
  localparam int OFS_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kill_i = 1'b0;
  logic slave_i = 1'b0;
  logic sync_i = 1'b0;
  logic [W-1:0] period_i = '0;
  logic [NCH*W-1:0] rise_i = '0;
  logic [NCH*W-1:0] fall_i = '0;
  logic signed [OFS_W-1:0] ofs_i = '0;
  logic [NCH-1:0] en_i = '0;
  logic [1:0] syncsel_i = '0;
  logic [NCH-1:0] pwm_o;
  logic sync_o;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  pwm6_edge_gen u0 (
    .clk(clk), .rst(rst), .kill_i(kill_i), .slave_i(slave_i), .sync_i(sync_i),
    .period_i(period_i), .rise_i(rise_i), .fall_i(fall_i), .ofs_i(ofs_i),
    .en_i(en_i), .syncsel_i(syncsel_i), .pwm_o(pwm_o), .sync_o(sync_o)
  );

  // reference model built from the requirements
  int m_ctr, m_per;
  int m_rise [NCH];
  int m_fall [NCH];
  bit m_sync_d;
  logic [NCH-1:0] m_pwm = '0;
  logic m_sync = 1'b0;

  function automatic int clampf(int f, int o, int p);
    int s;
    s = f + o;
    if (s < 0) return 0;
    if (s > p) return p;
    return s;
  endfunction

  always @(posedge clk) begin
    int pe;
    bit ld;
    logic [NCH-1:0] np;
    pe = (m_per < 2) ? 2 : m_per;
    ld = (m_ctr >= pe - 1) || (slave_i && sync_i && !m_sync_d);
    for (int c = 0; c < NCH; c++) begin
      if (rst || kill_i || !en_i[c]) np[c] = 1'b0;
      else if ((c == 2 && syncsel_i[0]) || (c == 3 && syncsel_i[1])) np[c] = (m_ctr == 0);
      else np[c] = (m_ctr >= m_rise[c]) && (m_ctr < m_fall[c]);
    end
    m_sync = rst ? 1'b0 : (!slave_i && m_ctr == 0);
    m_sync_d = sync_i;
    if (rst) begin
      m_ctr = 0; m_per = 0;
      for (int c = 0; c < NCH; c++) begin m_rise[c] = 0; m_fall[c] = 0; end
    end else if (ld) begin
      m_ctr = 0;
      m_per = int'(period_i);
      for (int c = 0; c < NCH; c++) begin
        m_rise[c] = int'(rise_i[c*W +: W]);
        m_fall[c] = clampf(int'(fall_i[c*W +: W]), int'(ofs_i), int'(period_i));
      end
    end else begin
      m_ctr = m_ctr + 1;
    end
    m_pwm = np;
  end

  task automatic check(string t, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(tag, int'(pwm_o), int'(m_pwm), "pwm_o");
    check(tag, int'(sync_o), int'(m_sync), "sync_o");
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_ch(int c, int r, int f);
    rise_i[c*W +: W] = W'(r);
    fall_i[c*W +: W] = W'(f);
  endtask

  task automatic rand_edges(int p);
    for (int c = 0; c < NCH; c++)
      set_ch(c, $urandom_range(0, p + 8), $urandom_range(0, p + 8));
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt_s, cnt_h;
    void'($urandom(32'd2024));
    // R1: reset state
    tag = "R1";
    steps(5);
    check("R1", int'(pwm_o), 0, "pwm_o in reset");
    check("R1", int'(sync_o), 0, "sync_o in reset");
    rst = 1'b0;

    // R3 / R2 directed: period 20, channel 0 high from 2 to 10
    tag = "R3";
    period_i = W'(20); en_i = '1; ofs_i = '0;
    for (int c = 0; c < NCH; c++) set_ch(c, 2 + c, 10 + c);
    steps(45);
    cnt_s = 0; cnt_h = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      cnt_s += int'(sync_o);
      cnt_h += int'(pwm_o[0]);
    end
    check("R2", cnt_s, 3, "sync pulses in 3 periods");
    check("R3", cnt_h, 24, "ch0 high cycles in 3 periods");

    // R4: mid-period edge changes are shadowed
    tag = "R4";
    for (int k = 0; k < 30; k++) begin
      steps($urandom_range(1, 15));
      set_ch($urandom_range(0, 5), $urandom_range(0, 20), $urandom_range(0, 20));
    end
    steps(25);

    // R5: offset clamp high and low
    tag = "R5";
    set_ch(0, 3, 15); ofs_i = 10'sd100;
    steps(45);
    cnt_h = 0;
    for (int i = 0; i < 40; i++) begin step(); cnt_h += int'(pwm_o[0]); end
    check("R5", cnt_h, 34, "ch0 high to period end under positive clamp");
    ofs_i = -10'sd200;
    steps(45);
    cnt_h = 0;
    for (int i = 0; i < 40; i++) begin step(); cnt_h += int'(pwm_o[0]); end
    check("R5", cnt_h, 0, "ch0 dead under negative clamp");
    for (int k = 0; k < 40; k++) begin
      ofs_i = OFS_W'($urandom_range(0, 60) - 30);
      rand_edges(20);
      steps($urandom_range(5, 45));
    end

    // R6: rise at or above fall
    tag = "R6";
    ofs_i = '0;
    set_ch(1, 12, 12); set_ch(4, 18, 5);
    steps(45);
    cnt_h = 0;
    for (int i = 0; i < 40; i++) begin step(); cnt_h += int'(pwm_o[1]) + int'(pwm_o[4]); end
    check("R6", cnt_h, 0, "inverted-edge channels high count");

    // R7: random enables
    tag = "R7";
    for (int k = 0; k < 200; k++) begin
      en_i = NCH'($urandom);
      if (k % 20 == 0) rand_edges(20);
      step();
    end
    en_i = '1;

    // R8: shutdown
    tag = "R8";
    set_ch(0, 0, 19);
    for (int k = 0; k < 200; k++) begin
      kill_i = ($urandom_range(0, 3) == 0);
      step();
    end
    kill_i = 1'b1; step();
    check("R8", int'(pwm_o), 0, "outputs one edge after kill");
    kill_i = 1'b0;

    // R9: sync-capable pins
    tag = "R9";
    for (int k = 0; k < 200; k++) begin
      if (k % 25 == 0) syncsel_i = 2'($urandom);
      step();
    end
    syncsel_i = 2'b11; steps(45);
    cnt_h = 0;
    for (int i = 0; i < 40; i++) begin step(); cnt_h += int'(pwm_o[2]) + int'(pwm_o[3]); end
    check("R9", cnt_h, 4, "sync pulses on channels 2 and 3 over 2 periods");
    syncsel_i = 2'b00;

    // R2: degenerate periods
    tag = "R2";
    period_i = W'(0); steps(45);
    period_i = W'(1); steps(20);
    cnt_s = 0;
    for (int i = 0; i < 20; i++) begin step(); cnt_s += int'(sync_o); end
    check("R2", cnt_s, 10, "sync pulses with period below minimum");

    // random master traffic (R3, R4, R5)
    tag = "R3";
    for (int k = 0; k < 150; k++) begin
      int p;
      p = $urandom_range(4, 63);
      period_i = W'(p);
      rand_edges(p);
      ofs_i = OFS_W'($urandom_range(0, 20) - 10);
      en_i = NCH'($urandom) | 6'b110011;
      steps($urandom_range(10, 120));
    end

    // R10: slave mode
    tag = "R10";
    slave_i = 1'b1; period_i = W'(50);
    for (int k = 0; k < 3000; k++) begin
      sync_i = ($urandom_range(0, 9) == 0);
      if (k % 300 == 0) rand_edges(50);
      step();
    end
    sync_i = 1'b0; step();
    sync_i = 1'b1; step();
    sync_i = 1'b0;
    cnt_s = 0;
    for (int i = 0; i < 30; i++) begin step(); cnt_s += int'(sync_o); end
    check("R10", cnt_s, 0, "sync_o pulses in slave mode");
    slave_i = 1'b0;
    steps(100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule